// File: doc/BRIEF.md
# Vector Fixed-Point and Configuration Register File

This block holds the control and status state a vector unit keeps next to its datapath: the element start index, the active length, the type word, the register byte length, and a packed fixed-point control word. The packed word carries a two-bit rounding mode and a one-bit saturation flag. Software reaches every register through one read port and one write port, both selected by a 12-bit CSR address. The read port is combinational. Each accepted write returns the register's new value one cycle later.

The rounding mode and the saturation flag each have their own address, and the packed word has a third. All three addresses map onto one physical copy of the two fields. A write through a single-field address therefore changes only that field and leaves the other as it was.

The datapath raises a saturation-event pulse whenever it clips a result. The pulse sets the sticky flag. Only a CSR write can clear the flag again. The current rounding mode and flag are also driven out directly for the datapath to use.

Top module: `vec_cfg_regs`

## Requirements
- R1: After reset the start index and the length are 0, the rounding mode is 00 and the saturation flag is 0. The type word has only its top bit (bit XLEN-1) set, and the byte-length register holds VLEN/8.
- R2: Seven addresses are implemented:
  - 0x008: start index
  - 0x009: saturation flag
  - 0x00A: rounding mode
  - 0x00F: packed word
  - 0xC20: length
  - 0xC21: type
  - 0xC22: byte length

  Any other address drives `csr_defined_o` low and reads 0. A write to it changes no register and produces no write response.
- R3: A write to 0x009 loads the saturation flag from write-data bit 0 and keeps the rounding mode.
- R4: A write to 0x00A loads the rounding mode from write-data bits [1:0] and keeps the saturation flag.
- R5: A write to 0x00F loads the rounding mode from write-data bits [2:1] and the saturation flag from bit 0.
- R6: A read of 0x009 returns the flag in bit 0. A read of 0x00A returns the mode in bits [1:0]. A read of 0x00F returns {mode, flag} in bits [2:0]. All other bits read 0.
- R7: A write to 0x008 keeps only the low log2(VLEN) bits of the write data, zero-extended.
- R8: Writes to 0xC20, 0xC21 and 0xC22 store the full XLEN-bit write data, and reads return it unchanged.
- R9: When `sat_evt_i` is high, the saturation flag is 1 after the next clock edge. A pulse never clears the flag.
- R10: A write to 0x009 or 0x00F in the same cycle as a saturation event sets the flag from the write data. A write to 0x00A in that cycle does not block the event.
- R11: The clock edge that accepts a write to an implemented address raises `wr_ack_o` for one cycle. In that cycle `wr_result_o` holds the target register's new value, in the same format a read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | Write strobe |
| csr_addr_i | input | 12 | CSR address for read and write |
| csr_wdata_i | input | XLEN | Write data |
| sat_evt_i | input | 1 | Saturation event from the datapath |
| csr_defined_o | output | 1 | Address is implemented |
| csr_rdata_o | output | XLEN | Combinational read data |
| wr_ack_o | output | 1 | Write response valid |
| wr_result_o | output | XLEN | Value the last write produced |
| rm_o | output | 2 | Current rounding mode |
| sat_o | output | 1 | Current saturation flag |

## Verification
Register updates and the write response both take effect at the clock edge that samples the write or event. They are visible from the moment after that edge. Decode and read data follow the address with no clock at all.

The bench drives each stimulus on a falling edge. Just after the rising edge it checks `wr_ack_o` and `wr_result_o`. It then drops the strobe and, with the address unchanged, checks the combinational read-back before the next falling edge. Every expected value therefore lands in the one cycle where it is due.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
  localparam int ADDR_W = 12;
  localparam int NCSR   = 7;

  localparam int IX_VSTART = 0;
  localparam int IX_SAT    = 1;
  localparam int IX_RM     = 2;
  localparam int IX_FXP    = 3;
  localparam int IX_VL     = 4;
  localparam int IX_VTYPE  = 5;
  localparam int IX_VLENB  = 6;

  localparam logic [ADDR_W-1:0] A_VSTART = 12'h008;
  localparam logic [ADDR_W-1:0] A_SAT    = 12'h009;
  localparam logic [ADDR_W-1:0] A_RM     = 12'h00A;
  localparam logic [ADDR_W-1:0] A_FXP    = 12'h00F;
  localparam logic [ADDR_W-1:0] A_VL     = 12'hC20;
  localparam logic [ADDR_W-1:0] A_VTYPE  = 12'hC21;
  localparam logic [ADDR_W-1:0] A_VLENB  = 12'hC22;

  function automatic logic [ADDR_W-1:0] addr_of(input int ix);
    case (ix)
      IX_VSTART: addr_of = A_VSTART;
      IX_SAT:    addr_of = A_SAT;
      IX_RM:     addr_of = A_RM;
      IX_FXP:    addr_of = A_FXP;
      IX_VL:     addr_of = A_VL;
      IX_VTYPE:  addr_of = A_VTYPE;
      default:   addr_of = A_VLENB;
    endcase
  endfunction

  typedef logic [NCSR-1:0] sel_t;
endpackage

// File: rtl/vcfg_addr_dec.sv
module vcfg_addr_dec
  import vcfg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output sel_t              sel_o,
  output logic              hit_o
);
  for (genvar i = 0; i < NCSR; i++) begin : g_cmp
    assign sel_o[i] = (addr_i == addr_of(i));
  end
  assign hit_o = |sel_o;
endmodule

// File: rtl/vcfg_fxp_reg.sv
// Shared rounding-mode / saturation state; three write views, one copy.
module vcfg_fxp_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_sat_i,
  input  logic       we_rm_i,
  input  logic       we_all_i,
  input  logic [2:0] wd_i,
  input  logic       sat_evt_i,
  output logic [1:0] rm_q_o,
  output logic       sat_q_o,
  output logic [1:0] rm_d_o,
  output logic       sat_d_o
);
  logic [1:0] rm_q;
  logic       sat_q;

  always_comb begin
    rm_d_o  = rm_q;
    sat_d_o = sat_q | sat_evt_i;
    if (we_rm_i)  rm_d_o = wd_i[1:0];
    if (we_all_i) rm_d_o = wd_i[2:1];
    // explicit flag write wins over a same-cycle event
    if (we_sat_i || we_all_i) sat_d_o = wd_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rm_q  <= 2'b00;
      sat_q <= 1'b0;
    end else begin
      rm_q  <= rm_d_o;
      sat_q <= sat_d_o;
    end
  end

  assign rm_q_o  = rm_q;
  assign sat_q_o = sat_q;
endmodule

// File: rtl/vcfg_word_reg.sv
module vcfg_word_reg #(
  parameter int          DW   = 64,
  parameter int          W    = 64,
  parameter int          KEEP = 64,
  parameter logic [W-1:0] RST = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wd_i,
  output logic [W-1:0]  q_o,
  output logic [W-1:0]  d_o
);
  logic [W-1:0] q;

  always_comb begin
    d_o = q;
    if (we_i) begin
      d_o = '0;
      d_o[KEEP-1:0] = wd_i[KEEP-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= RST;
    else         q <= d_o;
  end

  assign q_o = q;
endmodule

// File: rtl/vec_cfg_regs.sv
module vec_cfg_regs
  import vcfg_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int VLEN     = 128,
  parameter int VSTART_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                csr_we_i,
  input  logic [ADDR_W-1:0]   csr_addr_i,
  input  logic [XLEN-1:0]     csr_wdata_i,
  input  logic                sat_evt_i,
  output logic                csr_defined_o,
  output logic [XLEN-1:0]     csr_rdata_o,
  output logic                wr_ack_o,
  output logic [XLEN-1:0]     wr_result_o,
  output logic [1:0]          rm_o,
  output logic                sat_o
);
  localparam int VS_KEEP = $clog2(VLEN);
  localparam int NWORD   = 3;  // vl, vtype, vlenb

  typedef logic [NCSR-1:0][XLEN-1:0] view_t;

  function automatic logic [XLEN-1:0] word_rst(input int g);
    logic [XLEN-1:0] r;
    r = '0;
    if (g == IX_VTYPE - IX_VL) r[XLEN-1] = 1'b1;
    if (g == IX_VLENB - IX_VL) r = XLEN'(VLEN / 8);
    return r;
  endfunction

  function automatic logic [XLEN-1:0] pick(input sel_t s, input view_t v);
    logic [XLEN-1:0] r;
    r = '0;
    for (int i = 0; i < NCSR; i++) if (s[i]) r |= v[i];
    return r;
  endfunction

  sel_t sel, we_sel;
  logic hit;

  vcfg_addr_dec u_dec (
    .addr_i (csr_addr_i),
    .sel_o  (sel),
    .hit_o  (hit)
  );

  assign we_sel = sel & {NCSR{csr_we_i}};

  logic [1:0] rm_q, rm_d;
  logic       sat_q, sat_d;

  vcfg_fxp_reg u_fxp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_sat_i  (we_sel[IX_SAT]),
    .we_rm_i   (we_sel[IX_RM]),
    .we_all_i  (we_sel[IX_FXP]),
    .wd_i      (csr_wdata_i[2:0]),
    .sat_evt_i (sat_evt_i),
    .rm_q_o    (rm_q),
    .sat_q_o   (sat_q),
    .rm_d_o    (rm_d),
    .sat_d_o   (sat_d)
  );

  logic [VSTART_W-1:0] vs_q, vs_d;

  vcfg_word_reg #(.DW(XLEN), .W(VSTART_W), .KEEP(VS_KEEP), .RST('0)) u_vstart (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_sel[IX_VSTART]),
    .wd_i   (csr_wdata_i),
    .q_o    (vs_q),
    .d_o    (vs_d)
  );

  logic [NWORD-1:0][XLEN-1:0] wq, wd;

  for (genvar g = 0; g < NWORD; g++) begin : g_word
    vcfg_word_reg #(.DW(XLEN), .W(XLEN), .KEEP(XLEN), .RST(word_rst(g))) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (we_sel[IX_VL+g]),
      .wd_i   (csr_wdata_i),
      .q_o    (wq[g]),
      .d_o    (wd[g])
    );
  end

  view_t cur_v, nxt_v;

  always_comb begin
    cur_v            = '0;
    cur_v[IX_VSTART] = XLEN'(vs_q);
    cur_v[IX_SAT]    = XLEN'(sat_q);
    cur_v[IX_RM]     = XLEN'(rm_q);
    cur_v[IX_FXP]    = XLEN'({rm_q, sat_q});
    nxt_v            = '0;
    nxt_v[IX_VSTART] = XLEN'(vs_d);
    nxt_v[IX_SAT]    = XLEN'(sat_d);
    nxt_v[IX_RM]     = XLEN'(rm_d);
    nxt_v[IX_FXP]    = XLEN'({rm_d, sat_d});
    for (int g = 0; g < NWORD; g++) begin
      cur_v[IX_VL+g] = wq[g];
      nxt_v[IX_VL+g] = wd[g];
    end
  end

  assign csr_defined_o = hit;
  assign csr_rdata_o   = pick(sel, cur_v);

  logic            ack_q;
  logic [XLEN-1:0] res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      res_q <= '0;
    end else begin
      ack_q <= csr_we_i & hit;
      if (csr_we_i & hit) res_q <= pick(sel, nxt_v);
    end
  end

  assign wr_ack_o    = ack_q;
  assign wr_result_o = res_q;
  assign rm_o        = rm_q;
  assign sat_o       = sat_q;
endmodule

// File: rtl/vcfg_chk.sv
module vcfg_chk
  import vcfg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              csr_we_i,
  input logic [ADDR_W-1:0] csr_addr_i,
  input logic [XLEN-1:0]   csr_wdata_i,
  input logic              sat_evt_i,
  input logic              csr_defined_o,
  input logic [XLEN-1:0]   csr_rdata_o,
  input logic              wr_ack_o,
  input logic [1:0]        rm_o,
  input logic              sat_o
);
  logic flag_wr;
  assign flag_wr = csr_we_i && (csr_addr_i == A_SAT || csr_addr_i == A_FXP);

  // R2
  undef_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_defined_o |-> csr_rdata_o == '0);

  // R2
  undef_write_inert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_we_i && !csr_defined_o && !sat_evt_i |=> rm_o == $past(rm_o) && sat_o == $past(sat_o));

  // R3
  sat_write_keeps_rm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_we_i && csr_addr_i == A_SAT |=> rm_o == $past(rm_o) && sat_o == $past(csr_wdata_i[0]));

  // R4
  rm_write_keeps_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_we_i && csr_addr_i == A_RM && !sat_evt_i |=> sat_o == $past(sat_o) && rm_o == $past(csr_wdata_i[1:0]));

  // R9
  evt_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_evt_i && !flag_wr |=> sat_o);

  // R9
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o && !flag_wr |=> sat_o);

  // R11
  ack_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_we_i && csr_defined_o |=> wr_ack_o);

  // R11
  no_ack_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(csr_we_i && csr_defined_o) |=> !wr_ack_o);
endmodule

bind vec_cfg_regs vcfg_chk #(.XLEN(XLEN)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .csr_we_i      (csr_we_i),
  .csr_addr_i    (csr_addr_i),
  .csr_wdata_i   (csr_wdata_i),
  .sat_evt_i     (sat_evt_i),
  .csr_defined_o (csr_defined_o),
  .csr_rdata_o   (csr_rdata_o),
  .wr_ack_o      (wr_ack_o),
  .rm_o          (rm_o),
  .sat_o         (sat_o)
);

// File: tb/tb_vec_cfg_regs.sv
module tb_vec_cfg_regs;
  localparam int PERIOD = 10;
  localparam int XLEN   = 64;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            csr_we_i = 1'b0;
  logic [11:0]     csr_addr_i = '0;
  logic [XLEN-1:0] csr_wdata_i = '0;
  logic            sat_evt_i = 1'b0;
  logic            csr_defined_o, wr_ack_o, sat_o;
  logic [XLEN-1:0] csr_rdata_o, wr_result_o;
  logic [1:0]      rm_o;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk_i = ~clk_i;

  vec_cfg_regs #(.XLEN(XLEN), .VLEN(128)) dut (.*);

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [63:0] wd;
    logic        evt;
    logic        def;
    logic [63:0] exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 12'h00F, 64'h0,                  1'b0, 1'b1, 64'h0,                  4'd1},  // R1
    '{1'b1, 12'h00A, 64'hFF,                 1'b0, 1'b1, 64'h3,                  4'd4},  // R4
    '{1'b1, 12'h009, 64'hFFFF_FFFF_FFFF_FFFE,1'b0, 1'b1, 64'h0,                  4'd3},  // R3
    '{1'b0, 12'h00F, 64'h0,                  1'b0, 1'b1, 64'h6,                  4'd6},  // R6
    '{1'b1, 12'h009, 64'h1,                  1'b0, 1'b1, 64'h1,                  4'd3},  // R3
    '{1'b0, 12'h00F, 64'h0,                  1'b0, 1'b1, 64'h7,                  4'd6},  // R6
    '{1'b1, 12'h00A, 64'h1,                  1'b0, 1'b1, 64'h1,                  4'd4},  // R4
    '{1'b0, 12'h00F, 64'h0,                  1'b0, 1'b1, 64'h3,                  4'd4},  // R4
    '{1'b1, 12'h00F, 64'hFFFF_FFFF_FFFF_FFFC,1'b0, 1'b1, 64'h4,                  4'd5},  // R5
    '{1'b0, 12'h00A, 64'h0,                  1'b0, 1'b1, 64'h2,                  4'd5},  // R5
    '{1'b0, 12'h009, 64'h0,                  1'b0, 1'b1, 64'h0,                  4'd5},  // R5
    '{1'b1, 12'h008, 64'hFFFF,               1'b0, 1'b1, 64'h7F,                 4'd7},  // R7
    '{1'b1, 12'hC20, 64'h1234_5678_9ABC_DEF0,1'b0, 1'b1, 64'h1234_5678_9ABC_DEF0,4'd8},  // R8
    '{1'b1, 12'hC21, 64'hD3,                 1'b0, 1'b1, 64'hD3,                 4'd8},  // R8
    '{1'b1, 12'hC22, 64'h20,                 1'b0, 1'b1, 64'h20,                 4'd8},  // R8
    '{1'b1, 12'h00B, 64'hFFFF_FFFF_FFFF_FFFF,1'b0, 1'b0, 64'h0,                  4'd2},  // R2
    '{1'b1, 12'h7FF, 64'hFFFF_FFFF_FFFF_FFFF,1'b0, 1'b0, 64'h0,                  4'd2},  // R2
    '{1'b0, 12'hC20, 64'h0,                  1'b0, 1'b1, 64'h1234_5678_9ABC_DEF0,4'd2},  // R2
    '{1'b0, 12'h00F, 64'h0,                  1'b0, 1'b1, 64'h4,                  4'd2}   // R2
  };

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // drive on falling edge, check response after rising edge, then read-back
  task automatic step(input logic we, input logic [11:0] a, input logic [63:0] wd,
                      input logic evt, input logic def, input logic [63:0] exp, input string rq);
    @(negedge clk_i);
    csr_we_i = we; csr_addr_i = a; csr_wdata_i = wd; sat_evt_i = evt;
    @(posedge clk_i);
    #1;
    check({rq, "/R11 ack"}, 64'(wr_ack_o), 64'(we & def));
    if (we && def) check({rq, "/R11 result"}, wr_result_o, exp);
    csr_we_i = 1'b0; sat_evt_i = 1'b0;
    #1;
    check({rq, " defined"}, 64'(csr_defined_o), 64'(def));
    check({rq, " rdata"}, csr_rdata_o, exp);
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state of the word registers
    step(0, 12'h008, 0, 0, 1, 64'h0, "R1 vstart");
    step(0, 12'hC20, 0, 0, 1, 64'h0, "R1 vl");
    step(0, 12'hC21, 0, 0, 1, 64'h8000_0000_0000_0000, "R1 vtype");
    step(0, 12'hC22, 0, 0, 1, 64'd16, "R1 vlenb");

    for (int i = 0; i < NV; i++)
      step(TBL[i].we, TBL[i].addr, TBL[i].wd, TBL[i].evt, TBL[i].def, TBL[i].exp,
           $sformatf("R%0d row%0d", TBL[i].rq, i));

    // state now: rm=2 sat=0
    // R9 event sets flag, stays set
    step(0, 12'h009, 0, 1, 1, 64'h1, "R9 set");
    step(0, 12'h009, 0, 0, 1, 64'h1, "R9 sticky");
    step(0, 12'h009, 0, 1, 1, 64'h1, "R9 repeat");
    check("R9 sat_o", 64'(sat_o), 64'h1);
    // R10 write wins over event
    step(1, 12'h009, 64'h0, 1, 1, 64'h0, "R10 sat write");
    step(1, 12'h00F, 64'h6, 1, 1, 64'h6, "R10 fxp write");
    step(1, 12'h00A, 64'h0, 1, 1, 64'h0, "R10 rm write");
    step(0, 12'h00F, 0, 0, 1, 64'h1, "R10 event kept");
    check("R10 rm_o", 64'(rm_o), 64'h0);

    // R1 asynchronous reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1 async sat", 64'(sat_o), 64'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(0, 12'h00F, 0, 0, 1, 64'h0, "R1 fxp");
    step(0, 12'h008, 0, 0, 1, 64'h0, "R1 vstart2");
    step(0, 12'hC21, 0, 0, 1, 64'h8000_0000_0000_0000, "R1 vtype2");
    step(0, 12'hC22, 0, 0, 1, 64'd16, "R1 vlenb2");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule